// File: doc/BRIEF.md
# Display Controller Register Bank

This block is the memory-mapped control register file of a palette-based framebuffer controller. A host bus issues word, halfword or byte reads and writes into a 2 MiB window. The block decodes each access to one of these targets: a fixed identity word, the two display-size registers, the control word, the frame-start address, the pointer position, the three-entry pointer colour table, the 256-entry colour table and the 512-entry pointer bitmap. Registered values and single-cycle write strobes go to the pixel compositor. Video timing and frame storage live elsewhere.

The size registers are scaled on the way in and out. Horizontal size is written in groups of four pixels. Vertical size is written in half-lines. The control word carries a 3-bit pixel-depth code, which is decoded into a bit count. A narrow write takes the current readback of its aligned word, replaces only the addressed lanes and stores the result. Locations that read as zero therefore merge with zero. The block also holds the per-frame interrupt: the display engine's frame tick sets it, and any bus write clears it. A write to the reset location clears the whole bank in one cycle.

Top module: `dcr_regbank`

## Requirements
- R1: A read of offset 0x000000 returns 0x00000010, and writes to that offset change nothing.
- R2: A word write of v to 0x080118 sets `hsize_px` to v*4, truncated to 32 bits. A read of that offset returns `hsize_px`/4.
- R3: A word write of v to 0x080150 sets `vsize_ln` to v/2, rounded down. A read returns `vsize_ln`*2, so an odd written value reads back with bit 0 cleared.
- R4: A write to 0x080300 stores the word on `ctrl_word`. `depth_bits` follows bits 22:20 of that word: codes 0..7 give 1, 2, 4, 8, 15, 16, 0 and 0. After reset the depth is 1.
- R5: A write anywhere in 0x080800..0x080FFF pulses `pal_we` with `pal_index` = (addr-0x080800)>>3 and `pal_rgb` = data[23:0]. Reads of this window return 0.
- R6: Offsets 0x080508..0x08051F hold three pointer colours at index (addr-0x080508)>>3. A write pulses `cpal_we`, `cpal_index` and `cpal_rgb`. A read returns {8'h00, stored rgb}.
- R7: Offsets 0x081000..0x081FFF hold the pointer bitmap at index (addr-0x081000)>>3. A write stores data[15:0] and pulses `pat_we`, `pat_index` and `pat_bits`. A read returns the stored 16 bits, zero-extended.
- R8: A write to 0x080400 drives `top_addr`, and a write to 0x080638 drives `cursor_pos`. Both offsets read as 0. Writes to the timing offsets (0x080000, 0x080108..0x080170, 0x080200) have no visible effect. Reads of any undecoded offset return 0.
- R9: A write to 0x180000 clears every register, the pointer colours, the bitmap and `irq`, and pulses `tables_clear` for one cycle.
- R10: `bus_size` 0 is a byte access: lane addr[1:0], bits 8n+7:8n, taken from wdata[7:0]. `bus_size` 1 is a halfword access: lane addr[1], taken from wdata[15:0]. `bus_size` 2 is a full word. Lanes that are not addressed keep the current readback of the aligned word.
- R11: `frame_tick` sets `irq` on the next cycle. A write without a tick clears it. If a tick and a write arrive together, the tick wins.
- R12: A read in cycle t gives `bus_rvalid` high for exactly one cycle at t+1. `bus_rdata` then holds the value as of cycle t.
- R13: Write strobes appear the cycle after the write, last one cycle, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | 21 | byte address within the window |
| bus_wr | input | 1 | write request |
| bus_rd | input | 1 | read request |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | write data, right-justified for narrow writes |
| bus_rdata | output | 32 | registered read data |
| bus_rvalid | output | 1 | read data valid |
| frame_tick | input | 1 | one pulse per refreshed frame |
| irq | output | 1 | frame interrupt |
| hsize_px | output | 32 | width in pixels |
| vsize_ln | output | 32 | height in lines |
| ctrl_word | output | 32 | control word |
| depth_bits | output | 5 | decoded bits per pixel |
| top_addr | output | 32 | frame start address |
| cursor_pos | output | 32 | pointer position word |
| pal_we | output | 1 | colour entry write strobe |
| pal_index | output | 8 | colour entry index |
| pal_rgb | output | 24 | colour entry value |
| cpal_we | output | 1 | pointer colour write strobe |
| cpal_index | output | 2 | pointer colour index |
| cpal_rgb | output | 24 | pointer colour value |
| pat_we | output | 1 | bitmap write strobe |
| pat_index | output | 9 | bitmap word index |
| pat_bits | output | 16 | bitmap word value |
| tables_clear | output | 1 | clear pulse after a reset write |

## Verification
Register outputs and write strobes change on the clock edge that captures a write, so they are due one cycle after the write is presented. Read data and `bus_rvalid` are also due one cycle after the read request. The interrupt follows a tick or a write by one cycle. The bench drives inputs and samples outputs on the falling edge. Each write task returns on the falling edge that follows its capture edge, so register and strobe checks land in the due cycle. A read pushes its expected word into a queue, and a monitor pops the queue on every falling edge where `bus_rvalid` is high. A later falling edge then confirms that the strobe or `bus_rvalid` has dropped again.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned ADDR_W = 21;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [ADDR_W-1:0] A_IDENT = 21'h000000;
  localparam logic [ADDR_W-1:0] A_HSIZE = 21'h080118;
  localparam logic [ADDR_W-1:0] A_VSIZE = 21'h080150;
  localparam logic [ADDR_W-1:0] A_CTRL  = 21'h080300;
  localparam logic [ADDR_W-1:0] A_TOP   = 21'h080400;
  localparam logic [ADDR_W-1:0] A_CPAL  = 21'h080508;
  localparam logic [ADDR_W-1:0] A_CPOS  = 21'h080638;
  localparam logic [ADDR_W-1:0] A_PAL   = 21'h080800;
  localparam logic [ADDR_W-1:0] A_PAT   = 21'h081000;
  localparam logic [ADDR_W-1:0] A_CLEAR = 21'h180000;

  localparam logic [WORD_W-1:0] IDENT_WORD = 32'h0000_0010;

  typedef struct packed {
    logic ident;
    logic hsize;
    logic vsize;
    logic ctrl;
    logic top;
    logic cpos;
    logic clear;
    logic pal;
    logic cpal;
    logic pat;
  } dcr_hit_t;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    depth_of = 5'd1;
      3'd1:    depth_of = 5'd2;
      3'd2:    depth_of = 5'd4;
      3'd3:    depth_of = 5'd8;
      3'd4:    depth_of = 5'd15;
      3'd5:    depth_of = 5'd16;
      default: depth_of = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dcr_pkg::*;
#(
  parameter int unsigned PAL_DEPTH = 256,
  parameter int unsigned PAT_DEPTH = 512,
  parameter int unsigned CPAL_N    = 3,
  localparam int unsigned PAL_IW   = $clog2(PAL_DEPTH),
  localparam int unsigned PAT_IW   = $clog2(PAT_DEPTH),
  localparam int unsigned CPAL_IW  = $clog2(CPAL_N)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output dcr_hit_t           hit_o,
  output logic [PAL_IW-1:0]  pal_idx_o,
  output logic [PAT_IW-1:0]  pat_idx_o,
  output logic [CPAL_IW-1:0] cpal_idx_o
);
  localparam logic [ADDR_W-1:0] PAL_END  = A_PAL  + ADDR_W'(PAL_DEPTH * 8);
  localparam logic [ADDR_W-1:0] PAT_END  = A_PAT  + ADDR_W'(PAT_DEPTH * 8);
  localparam logic [ADDR_W-1:0] CPAL_END = A_CPAL + ADDR_W'(CPAL_N * 8);

  always_comb begin
    hit_o       = '0;
    hit_o.pal   = (addr_i >= A_PAL)  && (addr_i < PAL_END);
    hit_o.pat   = (addr_i >= A_PAT)  && (addr_i < PAT_END);
    hit_o.cpal  = (addr_i >= A_CPAL) && (addr_i < CPAL_END);
    hit_o.ident = (addr_i == A_IDENT);
    hit_o.hsize = (addr_i == A_HSIZE);
    hit_o.vsize = (addr_i == A_VSIZE);
    hit_o.ctrl  = (addr_i == A_CTRL);
    hit_o.top   = (addr_i == A_TOP);
    hit_o.cpos  = (addr_i == A_CPOS);
    hit_o.clear = (addr_i == A_CLEAR);
  end

  assign pal_idx_o  = PAL_IW'((addr_i - A_PAL) >> 3);
  assign pat_idx_o  = PAT_IW'((addr_i - A_PAT) >> 3);
  assign cpal_idx_o = CPAL_IW'((addr_i - A_CPAL) >> 3);
endmodule

// File: rtl/dcr_lane_merge.sv
module dcr_lane_merge
  import dcr_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned W    = LANES * 8
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] data_i,
  input  logic [1:0]   size_i,
  input  logic [1:0]   lane_i,
  output logic [W-1:0] merged_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [1:0] KL = 2'(k);
    logic take;
    logic [7:0] src;
    always_comb begin
      take = 1'b0;
      src  = data_i[8*k +: 8];
      case (size_i)
        SZ_BYTE: begin
          take = (lane_i == KL);
          src  = data_i[7:0];
        end
        SZ_HALF: begin
          take = (lane_i[1] == KL[1]);
          src  = data_i[8*(k%2) +: 8];
        end
        default: take = 1'b1;
      endcase
    end
    assign merged_o[8*k +: 8] = take ? src : old_i[8*k +: 8];
  end
endmodule

// File: rtl/dcr_pat_store.sv
module dcr_pat_store #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] live_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) live_q <= '0;
    else if (we_i)    live_q[widx_i] <= 1'b1;
  end

  assign rdata_o = live_q[ridx_i] ? mem[ridx_i] : '0;

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (rdata_o == '0));
endmodule

// File: rtl/dcr_regbank.sv
module dcr_regbank
  import dcr_pkg::*;
#(
  parameter int unsigned PAL_DEPTH = 256,
  parameter int unsigned PAT_DEPTH = 512,
  parameter int unsigned PAT_W     = 16,
  parameter int unsigned CPAL_N    = 3,
  parameter int unsigned RGB_W     = 24,
  localparam int unsigned PAL_IW   = $clog2(PAL_DEPTH),
  localparam int unsigned PAT_IW   = $clog2(PAT_DEPTH),
  localparam int unsigned CPAL_IW  = $clog2(CPAL_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [20:0]        bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic               frame_tick,
  output logic               irq,
  output logic [31:0]        hsize_px,
  output logic [31:0]        vsize_ln,
  output logic [31:0]        ctrl_word,
  output logic [4:0]         depth_bits,
  output logic [31:0]        top_addr,
  output logic [31:0]        cursor_pos,
  output logic               pal_we,
  output logic [PAL_IW-1:0]  pal_index,
  output logic [RGB_W-1:0]   pal_rgb,
  output logic               cpal_we,
  output logic [CPAL_IW-1:0] cpal_index,
  output logic [RGB_W-1:0]   cpal_rgb,
  output logic               pat_we,
  output logic [PAT_IW-1:0]  pat_index,
  output logic [PAT_W-1:0]   pat_bits,
  output logic               tables_clear
);
  logic [ADDR_W-1:0]  word_addr;
  dcr_hit_t           hit;
  logic [PAL_IW-1:0]  pal_idx;
  logic [PAT_IW-1:0]  pat_idx;
  logic [CPAL_IW-1:0] cpal_idx;
  logic [31:0]        readback, wr_word;
  logic [PAT_W-1:0]   pat_rd;
  logic               soft_clr;
  logic               pat_wr;
  logic [RGB_W-1:0]   cpal_q [CPAL_N];

  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign soft_clr  = bus_wr && hit.clear;
  assign pat_wr    = bus_wr && hit.pat;

  dcr_decode #(.PAL_DEPTH(PAL_DEPTH), .PAT_DEPTH(PAT_DEPTH), .CPAL_N(CPAL_N)) u_decode (
    .addr_i(word_addr), .hit_o(hit), .pal_idx_o(pal_idx),
    .pat_idx_o(pat_idx), .cpal_idx_o(cpal_idx)
  );

  dcr_pat_store #(.DEPTH(PAT_DEPTH), .W(PAT_W)) u_pat (
    .clk(clk), .rst(rst), .clr_i(soft_clr), .we_i(pat_wr),
    .widx_i(pat_idx), .wdata_i(wr_word[PAT_W-1:0]),
    .ridx_i(pat_idx), .rdata_o(pat_rd)
  );

  always_comb begin
    readback = '0;
    if (hit.ident)     readback = IDENT_WORD;
    else if (hit.hsize) readback = hsize_px >> 2;
    else if (hit.vsize) readback = vsize_ln << 1;
    else if (hit.ctrl)  readback = ctrl_word;
    else if (hit.cpal)  readback = 32'(cpal_q[cpal_idx]);
    else if (hit.pat)   readback = 32'(pat_rd);
  end

  dcr_lane_merge #(.LANES(4)) u_merge (
    .old_i(readback), .data_i(bus_wdata), .size_i(bus_size),
    .lane_i(bus_addr[1:0]), .merged_o(wr_word)
  );

  // scalar registers and pointer colours
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      hsize_px   <= '0;
      vsize_ln   <= '0;
      ctrl_word  <= '0;
      depth_bits <= depth_of(3'd0);
      top_addr   <= '0;
      cursor_pos <= '0;
      for (int i = 0; i < CPAL_N; i++) cpal_q[i] <= '0;
    end else if (bus_wr) begin
      if (hit.hsize) hsize_px <= wr_word << 2;
      if (hit.vsize) vsize_ln <= wr_word >> 1;
      if (hit.ctrl) begin
        ctrl_word  <= wr_word;
        depth_bits <= depth_of(wr_word[22:20]);
      end
      if (hit.top)  top_addr   <= wr_word;
      if (hit.cpos) cursor_pos <= wr_word;
      if (hit.cpal) cpal_q[cpal_idx] <= wr_word[RGB_W-1:0];
    end
  end

  // compositor strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      pal_we       <= 1'b0;
      cpal_we      <= 1'b0;
      pat_we       <= 1'b0;
      tables_clear <= 1'b0;
      pal_index    <= '0;
      pal_rgb      <= '0;
      cpal_index   <= '0;
      cpal_rgb     <= '0;
      pat_index    <= '0;
      pat_bits     <= '0;
    end else begin
      pal_we       <= bus_wr && hit.pal;
      cpal_we      <= bus_wr && hit.cpal;
      pat_we       <= pat_wr;
      tables_clear <= soft_clr;
      if (bus_wr && hit.pal) begin
        pal_index <= pal_idx;
        pal_rgb   <= wr_word[RGB_W-1:0];
      end
      if (bus_wr && hit.cpal) begin
        cpal_index <= cpal_idx;
        cpal_rgb   <= wr_word[RGB_W-1:0];
      end
      if (pat_wr) begin
        pat_index <= pat_idx;
        pat_bits  <= wr_word[PAT_W-1:0];
      end
    end
  end

  // frame interrupt
  always_ff @(posedge clk) begin
    if (rst || soft_clr) irq <= 1'b0;
    else                 irq <= frame_tick || (irq && !bus_wr);
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= readback;
    end
  end

  p_rvalid_follows_rd_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_no_spurious_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  p_irq_raise_r11: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !(bus_wr && hit.clear)) |=> irq);
  p_irq_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !frame_tick) |=> !irq);
  p_strobe_onehot_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pal_we, cpal_we, pat_we, tables_clear}));
  p_strobe_after_write_r13: assert property (@(posedge clk) disable iff (rst)
    (pal_we || cpal_we || pat_we) |-> $past(bus_wr));
  p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (rst)
    tables_clear |-> (hsize_px == '0 && vsize_ln == '0 && ctrl_word == '0 && !irq));
  p_decode_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  p_hsize_scale_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit.hsize && bus_size == SZ_WORD) |=> hsize_px == {$past(bus_wdata[29:0]), 2'b00});
  p_vsize_scale_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit.vsize && bus_size == SZ_WORD) |=> vsize_ln == {1'b0, $past(bus_wdata[31:1])});
  p_depth_code3_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[22:20] == 3'd3) |-> depth_bits == 5'd8);
endmodule

// File: tb/dcr_regbank_tb.sv
module dcr_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, frame_tick = 1'b0, irq;
  logic [31:0] hsize_px, vsize_ln, ctrl_word, top_addr, cursor_pos;
  logic [4:0]  depth_bits;
  logic        pal_we, cpal_we, pat_we, tables_clear;
  logic [7:0]  pal_index;
  logic [23:0] pal_rgb, cpal_rgb;
  logic [1:0]  cpal_index;
  logic [8:0]  pat_index;
  logic [15:0] pat_bits;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  dcr_regbank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .frame_tick(frame_tick), .irq(irq),
    .hsize_px(hsize_px), .vsize_ln(vsize_ln), .ctrl_word(ctrl_word),
    .depth_bits(depth_bits), .top_addr(top_addr), .cursor_pos(cursor_pos),
    .pal_we(pal_we), .pal_index(pal_index), .pal_rgb(pal_rgb),
    .cpal_we(cpal_we), .cpal_index(cpal_index), .cpal_rgb(cpal_rgb),
    .pat_we(pat_we), .pat_index(pat_index), .pat_bits(pat_bits),
    .tables_clear(tables_clear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d,
                    input logic [1:0] sz, input logic tick);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1; frame_tick = tick;
    @(negedge clk);
    bus_wr = 1'b0; frame_tick = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) chk("R12 spurious rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset irq", 32'(irq), 32'd0);
    chk("R4 reset depth", 32'(depth_bits), 32'd1);
    chk("R2 reset hsize", hsize_px, 32'd0);

    // R1 identity
    rd(21'h000000, 32'h10, "R1 ident");
    wr(21'h000000, 32'h55, 2'd2, 1'b0);
    rd(21'h000000, 32'h10, "R1 ident after write");

    // R2 horizontal scaling
    wr(21'h080118, 32'h140, 2'd2, 1'b0);
    chk("R2 hsize", hsize_px, 32'h500);
    rd(21'h080118, 32'h140, "R2 hsize read");
    wr(21'h080118, 32'hC000_0001, 2'd2, 1'b0);
    chk("R2 hsize wrap", hsize_px, 32'h4);
    rd(21'h080118, 32'h1, "R2 hsize wrap read");

    // R3 vertical scaling
    wr(21'h080150, 32'h3C1, 2'd2, 1'b0);
    chk("R3 vsize", vsize_ln, 32'h1E0);
    rd(21'h080150, 32'h3C0, "R3 vsize read odd");

    // R4 depth table
    for (int c = 0; c < 8; c++) begin
      logic [4:0] dexp;
      dexp = (c == 0) ? 5'd1 : (c == 1) ? 5'd2 : (c == 2) ? 5'd4 : (c == 3) ? 5'd8 :
             (c == 4) ? 5'd15 : (c == 5) ? 5'd16 : 5'd0;
      wr(21'h080300, (32'(c) << 20) | 32'h400, 2'd2, 1'b0);
      chk("R4 depth", 32'(depth_bits), 32'(dexp));
      chk("R4 ctrl", ctrl_word, (32'(c) << 20) | 32'h400);
    end
    rd(21'h080300, 32'h0070_0400, "R4 ctrl read");

    // R5 colour palette
    wr(21'h08082C, 32'hAABB_CCDD, 2'd2, 1'b0);
    chk("R5 pal_we", 32'(pal_we), 32'd1);
    chk("R5 pal_index", 32'(pal_index), 32'd5);
    chk("R5 pal_rgb", 32'(pal_rgb), 32'hBBCCDD);
    @(negedge clk);
    chk("R13 pal_we one cycle", 32'(pal_we), 32'd0);
    wr(21'h080FF8, 32'h0001_0203, 2'd2, 1'b0);
    chk("R5 pal last index", 32'(pal_index), 32'd255);
    chk("R13 only pal strobe", 32'({cpal_we, pat_we}), 32'd0);
    rd(21'h080828, 32'h0, "R5 pal reads zero");

    // R6 pointer colours
    wr(21'h080518, 32'h0012_3456, 2'd2, 1'b0);
    chk("R6 cpal_we", 32'(cpal_we), 32'd1);
    chk("R6 cpal_index", 32'(cpal_index), 32'd2);
    chk("R6 cpal_rgb", 32'(cpal_rgb), 32'h123456);
    wr(21'h080508, 32'hFF65_4321, 2'd2, 1'b0);
    rd(21'h08051C, 32'h0012_3456, "R6 cpal read entry2");
    rd(21'h080508, 32'h0065_4321, "R6 cpal read entry0");

    // R7 pointer bitmap
    wr(21'h081FF8, 32'hFFFF_BEEF, 2'd2, 1'b0);
    chk("R7 pat_we", 32'(pat_we), 32'd1);
    chk("R7 pat_index", 32'(pat_index), 32'd511);
    chk("R7 pat_bits", 32'(pat_bits), 32'hBEEF);
    rd(21'h081FF8, 32'h0000_BEEF, "R7 pat read");
    rd(21'h081008, 32'h0, "R7 unwritten pat");

    // R8 top, pointer position, ignored and undecoded
    wr(21'h080400, 32'h0000_1234, 2'd2, 1'b0);
    chk("R8 top", top_addr, 32'h1234);
    wr(21'h080638, 32'h0040_0020, 2'd2, 1'b0);
    chk("R8 cursor", cursor_pos, 32'h0040_0020);
    rd(21'h080400, 32'h0, "R8 top reads zero");
    wr(21'h080110, 32'hFFFF_FFFF, 2'd2, 1'b0);
    wr(21'h080200, 32'hFFFF_FFFF, 2'd2, 1'b0);
    chk("R8 timing ignored hsize", hsize_px, 32'h4);
    chk("R8 timing ignored ctrl", ctrl_word, 32'h0070_0400);
    chk("R8 timing ignored top", top_addr, 32'h1234);
    rd(21'h080110, 32'h0, "R8 timing reads zero");
    rd(21'h000100, 32'h0, "R8 undecoded read");

    // R10 narrow writes
    wr(21'h080118, 32'h1122_3344, 2'd2, 1'b0);
    wr(21'h080119, 32'h0000_00AB, 2'd0, 1'b0);
    chk("R10 byte lane1", hsize_px, 32'h448A_AD10);
    rd(21'h080118, 32'h1122_AB44, "R10 byte read");
    wr(21'h08011A, 32'h0000_5566, 2'd1, 1'b0);
    chk("R10 half upper", hsize_px, 32'h559A_AD10);
    rd(21'h080118, 32'h1566_AB44, "R10 half read");
    wr(21'h081000, 32'h0000_1234, 2'd2, 1'b0);
    wr(21'h081000, 32'h0000_00CD, 2'd0, 1'b0);
    rd(21'h081000, 32'h0000_12CD, "R10 byte into pattern");
    wr(21'h080402, 32'h0000_9999, 2'd1, 1'b0);
    chk("R10 half merges zero readback", top_addr, 32'h9999_0000);

    // R11 interrupt
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    chk("R11 irq raised", 32'(irq), 32'd1);
    @(negedge clk);
    chk("R11 irq held", 32'(irq), 32'd1);
    wr(21'h080110, 32'h0, 2'd2, 1'b0);
    chk("R11 irq lowered by write", 32'(irq), 32'd0);
    wr(21'h080110, 32'h0, 2'd2, 1'b1);
    chk("R11 tick wins over write", 32'(irq), 32'd1);

    // R12 read latency
    rd(21'h080150, 32'h3C0, "R12 read");
    @(negedge clk);
    chk("R12 rvalid one cycle", 32'(bus_rvalid), 32'd0);

    // R9 soft reset
    wr(21'h180000, 32'h0, 2'd2, 1'b0);
    chk("R9 clear pulse", 32'(tables_clear), 32'd1);
    chk("R9 hsize", hsize_px, 32'd0);
    chk("R9 vsize", vsize_ln, 32'd0);
    chk("R9 ctrl", ctrl_word, 32'd0);
    chk("R9 depth", 32'(depth_bits), 32'd1);
    chk("R9 top", top_addr, 32'd0);
    chk("R9 cursor", cursor_pos, 32'd0);
    chk("R9 irq", 32'(irq), 32'd0);
    @(negedge clk);
    chk("R9 clear one cycle", 32'(tables_clear), 32'd0);
    rd(21'h081FF8, 32'h0, "R9 pattern cleared");
    rd(21'h080518, 32'h0, "R9 cpal cleared");
    rd(21'h080118, 32'h0, "R9 hsize read cleared");

    repeat (2) @(negedge clk);
    chk("R12 queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule